// File: doc/BRIEF.md
# Cartridge PRG/CHR bank mapper

This block translates addresses for a cartridge that sits on an 8-bit CPU bus and on a separate video pattern bus. Software programs it by writing into the upper half of the CPU map (0x8000-0xFFFF). Those writes land in a small set of control registers and in eight indirect bank registers. The block then turns each CPU address in 0x8000-0xFFFF into a program-ROM address, and each video address in 0x0000-0x1FFF into a character-ROM address.

It also drives the address-line select for the nametable memory, and the chip enable and write enable of an 8 KB work RAM at 0x6000-0x7FFF. Two mode bits change which windows can be switched. The program mode exchanges the first and third 8 KB CPU windows. The character mode exchanges the 2 KB-bank half of pattern space with the 1 KB-bank half.

The block has no data stream, so all pins are plain control and address signals with no valid/ready handshake. Writes are captured on the rising clock edge while `cpu_wr` is high. Every translated output is combinational from the current address and the registered state, so it reflects a write from the first edge after that write.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset, every bank register and both mode bits are 0, mirroring is vertical and work RAM is disabled. So 0x8000 maps to bank 0, 0xC000 maps to bank PRG_BANKS-2, and `wram_ce` is 0.
- R2: A CPU write with address bits 15:13 = 100 and bit 0 = 0 is bank-select. Its data bits 2:0 name the register (0-7) that later writes with bits 15:13 = 100 and bit 0 = 1 load with their full data byte. Any address in 0x8000-0x9FFF decodes the same way.
- R3: With program mode 0 (bank-select bit 6), the CPU windows map as follows. 0x8000-0x9FFF uses register 6, 0xA000-0xBFFF uses register 7, 0xC000-0xDFFF uses bank PRG_BANKS-2 and 0xE000-0xFFFF uses bank PRG_BANKS-1. `prg_addr` = {bank, cpu_addr[12:0]}.
- R4: With program mode 1, 0x8000-0x9FFF uses bank PRG_BANKS-2 and 0xC000-0xDFFF uses register 6, while 0xA000-0xBFFF keeps register 7.
- R5: 0xE000-0xFFFF maps to bank PRG_BANKS-1 in both program modes.
- R6: With character mode 0 (bank-select bit 7), video 0x0000-0x0FFF is served by the 2 KB registers 0 and 1, split on A11. Video 0x1000-0x1FFF is served by 1 KB registers 2, 3, 4 and 5, chosen by A11:A10. `chr_addr` = {bank, ppu_addr[9:0]}.
- R7: With character mode 1 the two halves exchange places. Registers 2-5 serve 0x0000-0x0FFF, and registers 0 and 1 serve 0x1000-0x1FFF.
- R8: Registers 0 and 1 ignore their bit 0. Video A10 supplies the low bit of the 1 KB bank, so each selects a 2 KB-aligned pair.
- R9: Bank numbers are truncated to log2(PRG_BANKS) bits for program and log2(CHR_BANKS) bits for character space.
- R10: A write with address bits 15:13 = 101 and bit 0 = 0 sets mirroring from data bit 0 (0 vertical, 1 horizontal). `nt_a10` copies video A10 when vertical and video A11 when horizontal.
- R11: While `four_screen` is 1, `nt_a10` copies video A10 whatever the mirroring setting.
- R12: A write with address bits 15:13 = 101 and bit 0 = 1 sets work-RAM control: data bit 7 enables it, and data bit 6 makes it read-only. `wram_ce` is the enable bit AND cpu_addr in 0x6000-0x7FFF. `wram_we` is `wram_ce` AND `cpu_wr` AND NOT read-only.
- R13: Writes below 0x8000, and writes at 0xC000-0xFFFF, change no bank register, mode bit, mirroring or work-RAM setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe, sampled on the rising edge |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| ppu_addr | input | 14 | Video-chip address |
| four_screen | input | 1 | Strap: the cartridge supplies its own four nametables |
| prg_addr | output | log2(PRG_BANKS)+13 | Program-ROM address |
| chr_addr | output | log2(CHR_BANKS)+10 | Character-ROM address |
| nt_a10 | output | 1 | Nametable memory address line 10 |
| wram_ce | output | 1 | Work-RAM chip enable |
| wram_we | output | 1 | Work-RAM write enable |

## Verification
The bench builds the block with PRG_BANKS = 16 and CHR_BANKS = 32. With these sizes the fixed windows land on banks 14 and 15, where a wrong last-bank calculation shows up. Bank values written above the ROM size, such as 0x13 and 0x21, must wrap through truncation. The smaller address widths also keep every expected address short enough to write out by hand in the stimulus table.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam int REG_COUNT = 8;
  localparam int REG_W     = 8;

  // CPU address bits 14:13 within the 0x8000-0xFFFF half
  typedef enum logic [1:0] {
    PAGE_BANK   = 2'd0,
    PAGE_MIRROR = 2'd1,
    PAGE_IRQ_A  = 2'd2,
    PAGE_IRQ_B  = 2'd3
  } page_e;

  typedef struct packed {
    logic       chr_swap;
    logic       prg_swap;
    logic [2:0] target;
    logic       mirror_h;
    logic       wram_en;
    logic       wram_ro;
  } ctrl_t;

  typedef logic [REG_COUNT-1:0][REG_W-1:0] bank_file_t;
endpackage

// File: rtl/cbm_regfile.sv
module cbm_regfile
  import cbm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_wr,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  output ctrl_t       ctrl,
  output bank_file_t  banks
);
  page_e page;
  logic  hit_upper, wr_select, wr_load, wr_mirror, wr_protect;

  assign page       = page_e'(cpu_addr[14:13]);
  assign hit_upper  = cpu_wr && cpu_addr[15];
  assign wr_select  = hit_upper && (page == PAGE_BANK)   && !cpu_addr[0];
  assign wr_load    = hit_upper && (page == PAGE_BANK)   &&  cpu_addr[0];
  assign wr_mirror  = hit_upper && (page == PAGE_MIRROR) && !cpu_addr[0];
  assign wr_protect = hit_upper && (page == PAGE_MIRROR) &&  cpu_addr[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else begin
      if (wr_select) begin
        ctrl.target   <= cpu_wdata[2:0];
        ctrl.prg_swap <= cpu_wdata[6];
        ctrl.chr_swap <= cpu_wdata[7];
      end
      if (wr_mirror) ctrl.mirror_h <= cpu_wdata[0];
      if (wr_protect) begin
        ctrl.wram_en <= cpu_wdata[7];
        ctrl.wram_ro <= cpu_wdata[6];
      end
    end
  end

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_bank
    logic [REG_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                            q <= '0;
      else if (wr_load && ctrl.target == g)  q <= cpu_wdata;
    end
    assign banks[g] = q;
  end

  // R2
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b100 && cpu_addr[0])
      |=> banks[$past(ctrl.target)] == $past(cpu_wdata));

  // R13
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && cpu_addr[15:13] == 3'b100 && cpu_addr[0]) |=> $stable(banks));

  // R13
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && cpu_addr[15:14] == 2'b10) |=> $stable(ctrl));
endmodule

// File: rtl/cbm_prg_map.sv
module cbm_prg_map #(
  parameter int PRG_BANKS = 64,
  localparam int PB_W = $clog2(PRG_BANKS),
  localparam int PA_W = PB_W + 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prg_swap,
  input  logic [7:0]      r6,
  input  logic [7:0]      r7,
  input  logic [15:0]     cpu_addr,
  output logic [PA_W-1:0] prg_addr
);
  localparam logic [PB_W-1:0] LAST_BANK   = PB_W'(PRG_BANKS - 1);
  localparam logic [PB_W-1:0] PENULT_BANK = PB_W'(PRG_BANKS - 2);

  logic [PB_W-1:0] bank;
  logic            unused_hi;

  assign unused_hi = ^{r6, r7, cpu_addr[15]};

  always_comb begin
    unique case (cpu_addr[14:13])
      2'd0:    bank = prg_swap ? PENULT_BANK : r6[PB_W-1:0];
      2'd1:    bank = r7[PB_W-1:0];
      2'd2:    bank = prg_swap ? r6[PB_W-1:0] : PENULT_BANK;
      default: bank = LAST_BANK;
    endcase
  end

  assign prg_addr = {bank, cpu_addr[12:0]};

  // R5
  last_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b111) |-> (&prg_addr[PA_W-1:13]));

  // R4
  swap_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prg_swap && cpu_addr[15:13] == 3'b100) |-> prg_addr[PA_W-1:13] == PENULT_BANK);
endmodule

// File: rtl/cbm_chr_map.sv
module cbm_chr_map
  import cbm_pkg::*;
#(
  parameter int CHR_BANKS = 256,
  localparam int CB_W = $clog2(CHR_BANKS),
  localparam int CA_W = CB_W + 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chr_swap,
  input  bank_file_t      banks,
  input  logic [12:0]     ppu_addr,
  output logic [CA_W-1:0] chr_addr
);
  logic       fine_half;
  logic [7:0] bank;
  logic [2:0] fine_idx;
  logic       unused_hi;

  assign fine_half = ppu_addr[12] ^ chr_swap;
  assign fine_idx  = 3'd2 + {1'b0, ppu_addr[11:10]};

  always_comb begin
    if (!fine_half) bank = {banks[ppu_addr[11]][7:1], ppu_addr[10]};
    else            bank = banks[fine_idx];
  end

  assign unused_hi = ^bank;
  assign chr_addr  = {bank[CB_W-1:0], ppu_addr[9:0]};

  // R8
  pair_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ppu_addr[12] == chr_swap) |-> chr_addr[10] == ppu_addr[10]);
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cbm_pkg::*;
#(
  parameter int PRG_BANKS = 64,
  parameter int CHR_BANKS = 256
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cpu_wr,
  input  logic [15:0]                      cpu_addr,
  input  logic [7:0]                       cpu_wdata,
  input  logic [13:0]                      ppu_addr,
  input  logic                             four_screen,
  output logic [$clog2(PRG_BANKS)+12:0]    prg_addr,
  output logic [$clog2(CHR_BANKS)+9:0]     chr_addr,
  output logic                             nt_a10,
  output logic                             wram_ce,
  output logic                             wram_we
);
  ctrl_t      ctrl;
  bank_file_t banks;
  logic       wram_window;
  logic       unused_top;

  assign unused_top = ppu_addr[13];

  cbm_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .ctrl(ctrl), .banks(banks)
  );

  cbm_prg_map #(.PRG_BANKS(PRG_BANKS)) u_prg (
    .clk(clk), .rst_n(rst_n), .prg_swap(ctrl.prg_swap),
    .r6(banks[6]), .r7(banks[7]), .cpu_addr(cpu_addr), .prg_addr(prg_addr)
  );

  cbm_chr_map #(.CHR_BANKS(CHR_BANKS)) u_chr (
    .clk(clk), .rst_n(rst_n), .chr_swap(ctrl.chr_swap), .banks(banks),
    .ppu_addr(ppu_addr[12:0]), .chr_addr(chr_addr)
  );

  always_comb begin
    if (four_screen || !ctrl.mirror_h) nt_a10 = ppu_addr[10];
    else                               nt_a10 = ppu_addr[11];
  end

  assign wram_window = (cpu_addr[15:13] == 3'b011);
  assign wram_ce     = wram_window && ctrl.wram_en;
  assign wram_we     = wram_ce && cpu_wr && !ctrl.wram_ro;

  // R11
  four_screen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    four_screen |-> nt_a10 == ppu_addr[10]);

  // R12
  wram_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wram_we |-> (cpu_wr && cpu_addr[15:13] == 3'b011 && wram_ce));

  // R12
  wram_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wram_ce |-> cpu_addr[15:13] == 3'b011);
endmodule

// File: tb/cart_bank_mapper_test.sv
module cart_bank_mapper_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 46;

  typedef struct packed {
    logic [1:0]  op;   // 0 write, 1 program check, 2 character check, 3 nametable check
    logic [15:0] addr;
    logic [7:0]  data;
    logic [19:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{2'd0, 16'h8006, 8'h06, 20'h0, 4'd2},
    '{2'd0, 16'h8007, 8'h05, 20'h0, 4'd2},
    '{2'd0, 16'h8000, 8'h07, 20'h0, 4'd2},
    '{2'd0, 16'h8001, 8'h09, 20'h0, 4'd2},
    '{2'd1, 16'h8123, 8'h00, 20'h0A123, 4'd3},  // R3
    '{2'd1, 16'hA456, 8'h00, 20'h12456, 4'd3},  // R3
    '{2'd1, 16'hC000, 8'h00, 20'h1C000, 4'd3},  // R3
    '{2'd1, 16'hFFFF, 8'h00, 20'h1FFFF, 4'd5},  // R5
    '{2'd0, 16'h8000, 8'h46, 20'h0, 4'd4},
    '{2'd1, 16'h8010, 8'h00, 20'h1C010, 4'd4},  // R4
    '{2'd1, 16'hC010, 8'h00, 20'h0A010, 4'd4},  // R4
    '{2'd1, 16'hA000, 8'h00, 20'h12000, 4'd4},  // R4
    '{2'd1, 16'hE000, 8'h00, 20'h1E000, 4'd5},  // R5
    '{2'd0, 16'h9FFF, 8'h13, 20'h0, 4'd2},      // R2 mirrored decode
    '{2'd1, 16'hC001, 8'h00, 20'h06001, 4'd9},  // R9
    '{2'd0, 16'h8000, 8'h00, 20'h0, 4'd2},
    '{2'd0, 16'h8001, 8'h0B, 20'h0, 4'd2},
    '{2'd0, 16'h8000, 8'h01, 20'h0, 4'd2},
    '{2'd0, 16'h8001, 8'h04, 20'h0, 4'd2},
    '{2'd0, 16'h8000, 8'h02, 20'h0, 4'd2},
    '{2'd0, 16'h8001, 8'h21, 20'h0, 4'd2},
    '{2'd0, 16'h8000, 8'h05, 20'h0, 4'd2},
    '{2'd0, 16'h8001, 8'h1F, 20'h0, 4'd2},
    '{2'd2, 16'h0005, 8'h00, 20'h02805, 4'd8},  // R8
    '{2'd2, 16'h0405, 8'h00, 20'h02C05, 4'd8},  // R8
    '{2'd2, 16'h0C10, 8'h00, 20'h01410, 4'd6},  // R6
    '{2'd2, 16'h1000, 8'h00, 20'h00400, 4'd9},  // R9
    '{2'd2, 16'h1FFF, 8'h00, 20'h07FFF, 4'd6},  // R6
    '{2'd0, 16'h8000, 8'h80, 20'h0, 4'd7},
    '{2'd2, 16'h0000, 8'h00, 20'h00400, 4'd7},  // R7
    '{2'd2, 16'h0C01, 8'h00, 20'h07C01, 4'd7},  // R7
    '{2'd2, 16'h1405, 8'h00, 20'h02C05, 4'd7},  // R7
    '{2'd2, 16'h1800, 8'h00, 20'h01000, 4'd7},  // R7
    '{2'd3, 16'h2400, 8'h00, 20'h1, 4'd10},     // R10
    '{2'd3, 16'h2800, 8'h00, 20'h0, 4'd10},     // R10
    '{2'd0, 16'hA000, 8'h01, 20'h0, 4'd10},
    '{2'd3, 16'h2400, 8'h00, 20'h0, 4'd10},     // R10
    '{2'd3, 16'h2800, 8'h00, 20'h1, 4'd10},     // R10
    '{2'd0, 16'hC001, 8'hFF, 20'h0, 4'd13},
    '{2'd0, 16'hE000, 8'hFF, 20'h0, 4'd13},
    '{2'd0, 16'h7001, 8'hFF, 20'h0, 4'd13},
    '{2'd1, 16'hA000, 8'h00, 20'h12000, 4'd13}, // R13
    '{2'd2, 16'h0000, 8'h00, 20'h00400, 4'd13}, // R13
    '{2'd3, 16'h2800, 8'h00, 20'h1, 4'd13},     // R13
    '{2'd0, 16'hBFFE, 8'h00, 20'h0, 4'd10},
    '{2'd3, 16'h2800, 8'h00, 20'h0, 4'd10}      // R10
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [13:0] ppu_addr = '0;
  logic        four_screen = 1'b0;
  logic [16:0] prg_addr;
  logic [14:0] chr_addr;
  logic        nt_a10, wram_ce, wram_we;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_bank_mapper #(.PRG_BANKS(16), .CHR_BANKS(32)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .ppu_addr(ppu_addr), .four_screen(four_screen),
    .prg_addr(prg_addr), .chr_addr(chr_addr), .nt_a10(nt_a10),
    .wram_ce(wram_ce), .wram_we(wram_we)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic set_cpu(input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a;
    #1;
  endtask

  task automatic set_ppu(input logic [13:0] a);
    @(negedge clk);
    ppu_addr = a;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        2'd0: cpu_write(VECS[i].addr, VECS[i].data);
        2'd1: begin
          set_cpu(VECS[i].addr);
          chk($sformatf("R%0d prg vec%0d", VECS[i].req, i), 32'(prg_addr), 32'(VECS[i].exp));
        end
        2'd2: begin
          set_ppu(VECS[i].addr[13:0]);
          chk($sformatf("R%0d chr vec%0d", VECS[i].req, i), 32'(chr_addr), 32'(VECS[i].exp));
        end
        default: begin
          set_ppu(VECS[i].addr[13:0]);
          chk($sformatf("R%0d nt vec%0d", VECS[i].req, i), 32'(nt_a10), 32'(VECS[i].exp));
        end
      endcase
    end

    // R11: four-screen strap overrides horizontal mirroring
    cpu_write(16'hA000, 8'h01);
    @(negedge clk); four_screen = 1'b1;
    set_ppu(14'h2400); chk("R11 strap A10 high", 32'(nt_a10), 32'd1);
    set_ppu(14'h2800); chk("R11 strap A11 high", 32'(nt_a10), 32'd0);
    @(negedge clk); four_screen = 1'b0;
    set_ppu(14'h2800); chk("R10 horizontal after strap", 32'(nt_a10), 32'd1);

    // R12: work RAM enable and write protect
    set_cpu(16'h6000); chk("R12 disabled ce", 32'(wram_ce), 32'd0);
    cpu_write(16'hA001, 8'h80);
    set_cpu(16'h7FFF); chk("R12 enabled ce top", 32'(wram_ce), 32'd1);
    set_cpu(16'h8000); chk("R12 ce outside window", 32'(wram_ce), 32'd0);
    @(negedge clk); cpu_wr = 1'b1; cpu_addr = 16'h6005; cpu_wdata = 8'h00; #1;
    chk("R12 we writable", 32'(wram_we), 32'd1);
    @(negedge clk); cpu_wr = 1'b0;
    cpu_write(16'hA001, 8'hC0);
    @(negedge clk); cpu_wr = 1'b1; cpu_addr = 16'h6005; #1;
    chk("R12 we read-only", 32'(wram_we), 32'd0);
    chk("R12 ce read-only", 32'(wram_ce), 32'd1);
    @(negedge clk); cpu_wr = 1'b0;

    // R1: reset from a non-zero state
    cpu_write(16'h8000, 8'hC6);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    set_cpu(16'h8000); chk("R1 window0 bank0", 32'(prg_addr), 32'h00000);
    set_cpu(16'hC000); chk("R1 window2 penult", 32'(prg_addr), 32'h1C000);
    set_cpu(16'h6000); chk("R1 wram off", 32'(wram_ce), 32'd0);
    set_ppu(14'h1C00); chk("R1 chr bank0", 32'(chr_addr), 32'h0000);
    set_ppu(14'h2400); chk("R1 vertical", 32'(nt_a10), 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule